// File: doc/BRIEF.md
# Gated-Carry Multistage Up/Down Counter

This block is a wide binary counter built from a row of identical 4-bit up/down slices. Every slice runs on the same clock and sees the same direction and load inputs. Carry and borrow move between slices through gating, not through a rippling clock. A slice advances only when the global enable is active and every slice below it sits at its end value. That end value is 15 when counting up and 0 when counting down. As a result the whole word changes on a single rising edge, and no slice lags another.

An active-low load copies the preset word into every slice at once. The load is asynchronous and takes priority over counting. A combined terminal-count flag reports that the entire word has reached its end value for the present direction. The number of slices is a parameter, and the default of four gives a 16-bit count.

Top module: `cascade_updown_counter`

## Requirements
- R1: While `loadN` is low, `count` equals `preset` without waiting for a clock edge. A load pulse placed between two edges takes effect at once.
- R2: Rising clock edges that arrive while `loadN` is low leave `count` at `preset`, whatever `cntEnN` and `countUp` are.
- R3: With `loadN` high, `cntEnN` low and `countUp` = 1, each rising edge raises `count` by one.
- R4: With `loadN` high, `cntEnN` low and `countUp` = 0, each rising edge lowers `count` by one.
- R5: With `cntEnN` high, rising edges leave `count` unchanged in both directions.
- R6: A carry or borrow across any number of slice boundaries lands in the same edge. For example, 0x00FF counting up becomes 0x0100 after one edge, and 0x0100 counting down becomes 0x00FF after one edge.
- R7: `termCount` is 1 exactly when `count` is all ones with `countUp` = 1, or all zeros with `countUp` = 0. The flag does not depend on `cntEnN`, and it follows a change of `countUp` without a clock edge.
- R8: The count wraps modulo 2^(4·STAGES) in both directions: all ones goes to zero when counting up, and zero goes to all ones when counting down.
- R9: A change of `countUp` between edges sets the direction of the very next counting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all slices; state changes on the rising edge |
| cntEnN | input | 1 | Global count enable, active low |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down |
| loadN | input | 1 | Asynchronous parallel load, active low |
| preset | input | 4·STAGES | Value copied into the counter during a load |
| count | output | 4·STAGES | Full counter word |
| termCount | output | 1 | Whole-word terminal count for the current direction |

## Verification
Two functions can fall in the same cycle: the load and the count. The bench holds `loadN` low across rising edges while the enable is active, and checks that the count stays at the preset value. It also drops `loadN` briefly between edges in the middle of a run, then checks that the value appears before the next edge and that counting resumes from it. The terminal-count flag and a direction change can also coincide. The bench flips `countUp` at the wrap points and judges every result against a single wide reference counter.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int SLICE_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic countUp;
    logic runAny;
  } ccStrobe_t;
endpackage

// File: rtl/cc_slice.sv
module cc_slice
  import cc_pkg::*;
(
  input  logic               clk,
  input  logic               loadN,
  input  logic [SLICE_W-1:0] presetBits,
  input  logic               enable,
  input  logic               countUp,
  output logic [SLICE_W-1:0] q,
  output logic               sliceTc
);
  localparam logic [SLICE_W-1:0] ALL_ONES = {SLICE_W{1'b1}};

  always_ff @(posedge clk or negedge loadN) begin
    if (!loadN)       q <= presetBits;
    else if (enable)  q <= countUp ? q + 1'b1 : q - 1'b1;
  end

  // end value of this slice, independent of its own enable
  assign sliceTc = countUp ? (q == ALL_ONES) : (q == '0);
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              cntEnN,
  input  logic              countUp,
  input  logic [STAGES-1:0] sliceTc,
  output ccStrobe_t         strobe,
  output logic [STAGES-1:0] sliceEn,
  output logic              tcAll
);
  logic [STAGES:0] carryChain;

  assign strobe.countUp = countUp;
  assign strobe.runAny  = ~cntEnN;
  assign carryChain[0]  = ~cntEnN;

  // global enable is folded into every slice gate via the chain seed
  for (genvar k = 0; k < STAGES; k++) begin : g_gate
    assign sliceEn[k]      = carryChain[k];
    assign carryChain[k+1] = carryChain[k] & sliceTc[k];
  end

  assign tcAll = &sliceTc;
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int STAGES = 4,
  localparam int WIDTH = STAGES * SLICE_W
) (
  input  logic              clk,
  input  logic              loadN,
  input  logic [WIDTH-1:0]  preset,
  input  ccStrobe_t         strobe,
  input  logic [STAGES-1:0] sliceEn,
  output logic [WIDTH-1:0]  count,
  output logic [STAGES-1:0] sliceTc
);
  for (genvar k = 0; k < STAGES; k++) begin : g_slice
    cc_slice u_slice (
      .clk        (clk),
      .loadN      (loadN),
      .presetBits (preset[k*SLICE_W +: SLICE_W]),
      .enable     (sliceEn[k] & strobe.runAny),
      .countUp    (strobe.countUp),
      .q          (count[k*SLICE_W +: SLICE_W]),
      .sliceTc    (sliceTc[k])
    );
  end
endmodule

// File: rtl/cascade_updown_counter.sv
module cascade_updown_counter
  import cc_pkg::*;
#(
  parameter int STAGES = 4,
  localparam int WIDTH = STAGES * SLICE_W
) (
  input  logic             clk,
  input  logic             cntEnN,
  input  logic             countUp,
  input  logic             loadN,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);
  ccStrobe_t         strobe;
  logic [STAGES-1:0] sliceEn;
  logic [STAGES-1:0] sliceTc;

  cc_ctrl #(.STAGES(STAGES)) u_ctrl (
    .cntEnN  (cntEnN),
    .countUp (countUp),
    .sliceTc (sliceTc),
    .strobe  (strobe),
    .sliceEn (sliceEn),
    .tcAll   (termCount)
  );

  cc_datapath #(.STAGES(STAGES)) u_dp (
    .clk     (clk),
    .loadN   (loadN),
    .preset  (preset),
    .strobe  (strobe),
    .sliceEn (sliceEn),
    .count   (count),
    .sliceTc (sliceTc)
  );
endmodule

// File: rtl/cascade_updown_counter_chk.sv
module cascade_updown_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             cntEnN,
  input logic             countUp,
  input logic             loadN,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             termCount
);
  // set by any load since the last edge, so step checks skip that edge
  logic loadSeen;
  always_ff @(posedge clk or negedge loadN) begin
    if (!loadN) loadSeen <= 1'b1;
    else        loadSeen <= 1'b0;
  end

  p_up_step_r3: assert property (@(posedge clk) disable iff (!loadN || loadSeen)
    (!cntEnN && countUp) |=> (count == $past(count) + 1'b1));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!loadN || loadSeen)
    (!cntEnN && !countUp) |=> (count == $past(count) - 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!loadN || loadSeen)
    cntEnN |=> $stable(count));

  p_load_wins_r2: assert property (@(posedge clk) disable iff (loadN)
    $stable(preset) |-> (count == preset));

  always_comb begin
    if (loadN === 1'b1 && !$isunknown(count))
      p_term_flag_r7: assert (termCount == (countUp ? (&count) : ~(|count)));
  end
endmodule

bind cascade_updown_counter cascade_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .cntEnN    (cntEnN),
  .countUp   (countUp),
  .loadN     (loadN),
  .preset    (preset),
  .count     (count),
  .termCount (termCount)
);

// File: tb/cascade_updown_counter_test.sv
`timescale 1ns/1ps
module cascade_updown_counter_test;
  localparam int STAGES = 4;
  localparam int W = STAGES * 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         cntEnN = 1'b1;
  logic         countUp = 1'b1;
  logic         loadN = 1'b1;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         termCount;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] refCnt;

  always #4 clk = ~clk;

  cascade_updown_counter #(.STAGES(STAGES)) uut (
    .clk(clk), .cntEnN(cntEnN), .countUp(countUp), .loadN(loadN),
    .preset(preset), .count(count), .termCount(termCount)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expTc(input logic [W-1:0] v, input logic up);
    return up ? (v == ONES) : (v == '0);
  endfunction

  // load pulse placed between edges (R1)
  task automatic loadValue(input logic [W-1:0] v);
    @(negedge clk);
    preset = v;
    loadN  = 1'b0;
    #1;
    check("R1 async load", count, v);
    loadN  = 1'b1;
    refCnt = v;
  endtask

  // one rising edge, reference updated, then sampled away from the edge
  task automatic step(input string tag);
    logic en, up;
    en = ~cntEnN;
    up = countUp;
    @(posedge clk);
    #1;
    if (en) refCnt = up ? refCnt + 1'b1 : refCnt - 1'b1;
    check(tag, count, refCnt);
    check({tag, " R7 flag"}, {{(W-1){1'b0}}, termCount}, {{(W-1){1'b0}}, expTc(refCnt, countUp)});
  endtask

  task automatic testReset();
    loadValue('0);
    countUp = 1'b1; #1;
    check("R7 zero up", {{(W-1){1'b0}}, termCount}, '0);
    countUp = 1'b0; #1;
    check("R7 zero down, no edge", {{(W-1){1'b0}}, termCount}, 1);
  endtask

  task automatic testUpCarry();
    loadValue(16'h00FE);
    countUp = 1'b1; cntEnN = 1'b0;
    for (int i = 0; i < 3; i++) step("R3 up / R6 carry");
    loadValue(16'h0FFF);
    step("R6 three-slice carry");
    cntEnN = 1'b1;
  endtask

  task automatic testDownBorrow();
    loadValue(16'h0101);
    countUp = 1'b0; cntEnN = 1'b0;
    for (int i = 0; i < 3; i++) step("R4 down / R6 borrow");
    cntEnN = 1'b1;
  endtask

  task automatic testWrap();
    loadValue(ONES - 1);
    countUp = 1'b1; cntEnN = 1'b0;
    for (int i = 0; i < 3; i++) step("R8 wrap up");
    countUp = 1'b0;
    for (int i = 0; i < 3; i++) step("R8 wrap down / R9");
    cntEnN = 1'b1;
  endtask

  task automatic testHold();
    loadValue(ONES);
    countUp = 1'b1; cntEnN = 1'b1;
    for (int i = 0; i < 3; i++) step("R5 hold up, R7 flag ignores enable");
    countUp = 1'b0;
    step("R5 hold down");
  endtask

  task automatic testDirChange();
    loadValue(16'h1234);
    cntEnN = 1'b0;
    for (int i = 0; i < 12; i++) begin
      countUp = (i % 3) != 2;
      step("R9 direction change");
    end
    cntEnN = 1'b1;
  endtask

  task automatic testLoadOverride();
    @(negedge clk);
    cntEnN = 1'b0; countUp = 1'b1;
    preset = 16'hA5A5; loadN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R2 load overrides count", count, 16'hA5A5);
    end
    @(negedge clk);
    loadN = 1'b1; refCnt = 16'hA5A5;
    step("R2 resume after load");
    // load pulse in mid-run between edges
    loadValue(16'h7FFF);
    step("R1 count from mid-run load");
    cntEnN = 1'b1;
  endtask

  task automatic testMixed();
    loadValue(16'h0003);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cntEnN  = ($urandom % 5) == 0;
      countUp = ($urandom % 3) != 0;
      if (($urandom % 50) == 0) loadValue(16'($urandom));
      step("R3 R4 R5 mixed run");
    end
    cntEnN = 1'b1;
  endtask

  initial begin
    #1 loadN = 1'b0;
    #10 loadN = 1'b1;
    testReset();
    testUpCarry();
    testDownBorrow();
    testWrap();
    testHold();
    testDirChange();
    testLoadOverride();
    testMixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule